// File: doc/BRIEF.md
# NAND Flash Host Register Front End

This block sits between a processor's register bus and a NAND flash device. Software writes command bytes, address bytes and data words into registers. Each write becomes a tagged entry in a small write buffer. A cycle sequencer drains the buffer onto the flash bus, one entry at a time. For each entry it drives the command-latch, address-latch and active-low write or read strobes. The strobe stays low for a programmable number of clocks. The sequencer starts an entry only while the flash ready/busy line reads ready.

A byte read takes two steps. First, software writes any value to the read-request register. This queues a read cycle. When that cycle ends, the sampled bus value is held in the read-data register and the read-ready interrupt flag is set. Events are recorded in sticky interrupt flags, which software clears by writing ones to them. A mask reduces the flags to a single interrupt line. Page read and page write start bits mark a page transfer as pending. The transfer finishes after one page's worth of matching bus cycles, counted on a counter that software clears before each page.

Register offsets on the word address `regAddr`:

| Offset | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | interrupt flags |
| 3 | interrupt mask |
| 4 | command |
| 5 | address |
| 6 | data write |
| 7 | read request |
| 8 | read data |
| 9 | page control |
| 10 | counter reset |

Top module: `nand_host_regs`

## Requirements
- R1: After reset, status reads 0x11 with ready/busy high (not-busy and buffer-empty set), the interrupt flags read 0, `irqOut` is low and both strobes are high.
- R2: Writes to offsets 4 (command), 5 (address) and 6 (data write) are executed in write order. A command cycle raises `nandCle`, an address cycle raises `nandAle`, and a data cycle raises neither. Each of these drives `nandWeN` low with the written value on `nandIoOut` and `nandIoOe` high.
- R3: The buffer holds 4 entries. Status bit 1 is set while it holds 4 entries and status bit 4 while it holds none. A write that arrives while it is full is discarded and sets interrupt flag bit 1.
- R4: Control register (offset 0) layout: bit 0 selects the page size (0 = 256, 1 = 512), bit 1 selects the bus width (0 = 8-bit, 1 = 16-bit), bits 5:2 hold the read delay and bits 9:6 the write delay. A write-strobe cycle holds `nandWeN` low for write delay + 1 clocks. A read cycle holds `nandReN` low for read delay + 1 clocks.
- R5: A buffer entry starts only while `nandRdy` is high. Status bit 0 follows `nandRdy` one clock later.
- R6: A write of any value to offset 7 queues a read cycle. During the read cycle `nandIoOe` stays low and `nandReN` is low. At the end of the cycle the bus value is stored in the read-data register (offset 8) and interrupt flag bit 3 is set.
- R7: Interrupt flag bit 0 is set on a rising edge of `nandRdy`. Flag bit 2 is set when the buffer stops being full.
- R8: Writing the interrupt flag register clears exactly the bits written as 1. A flag set by hardware in the same clock as its clear stays set.
- R9: `irqOut` is high exactly when some flag is set whose bit is also set in the mask register (offset 3).
- R10: In the page control register (offset 9), bit 1 starts a page write (status bit 2) and bit 0 starts a page read (status bit 3). A page is 256 or 512 units, halved in 16-bit mode. A pending page write ends after that many data cycles and sets flag bit 4. A pending page read ends after that many read cycles.
- R11: Writing 1 to bit 0 of offset 10 clears the page unit counter, so the page then needs a full count of cycles.
- R12: In 8-bit mode, data cycles drive only the low byte of the written value and a read stores the low bus byte zero-extended. In 16-bit mode all 16 bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word offset |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 16 | Bus value driven during write cycles |
| nandIoOe | output | 1 | Bus output enable |
| nandIoIn | input | 16 | Bus value sampled on read cycles |
| nandRdy | input | 1 | Flash ready (high) / busy (low) |
| irqOut | output | 1 | Masked interrupt |

## Verification
A hardware event and a software clear can land on the same interrupt flag in the same clock. The bench provokes this by raising `nandRdy` in the same cycle as a register write that clears the not-busy flag. It then requires the flag to read back as set. A second collision is a buffer write arriving while the buffer is full and the flash is busy. The bench judges it by the overflow flag, the full flag, and by checking that only the first four queued values appear on the bus, in order, once the flash becomes ready.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2,
    KIND_READ = 2'd3
  } entryKind_e;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ACTIVE  = 2'd1,
    SEQ_RECOVER = 2'd2
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       pop;
    logic       done;
    logic       capture;
    entryKind_e doneKind;
  } seqStrobe_t;

  localparam logic [3:0] OFS_CTRL    = 4'd0;
  localparam logic [3:0] OFS_STATUS  = 4'd1;
  localparam logic [3:0] OFS_IRQ     = 4'd2;
  localparam logic [3:0] OFS_MASK    = 4'd3;
  localparam logic [3:0] OFS_CMD     = 4'd4;
  localparam logic [3:0] OFS_ADDR    = 4'd5;
  localparam logic [3:0] OFS_DATA    = 4'd6;
  localparam logic [3:0] OFS_RDREQ   = 4'd7;
  localparam logic [3:0] OFS_RDDATA  = 4'd8;
  localparam logic [3:0] OFS_PAGE    = 4'd9;
  localparam logic [3:0] OFS_CNTRST  = 4'd10;

  localparam int IRQ_NOTBUSY  = 0;
  localparam int IRQ_OVERFLOW = 1;
  localparam int IRQ_LEAVEFUL = 2;
  localparam int IRQ_RDREADY  = 3;
  localparam int IRQ_PGWDONE  = 4;
  localparam int IRQ_BITS     = 5;

endpackage

// File: rtl/nand_host_seq.sv
module nand_host_seq
  import nand_host_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEmpty,
  input  entryKind_e        headKind,
  input  logic [DATA_W-1:0] headData,
  input  logic              nandRdy,
  input  logic [DLY_W-1:0]  rdDly,
  input  logic [DLY_W-1:0]  wrDly,
  input  logic              wide,
  output seqStrobe_t        strobes,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandIoOut,
  output logic              nandIoOe
);

  seqState_e         state;
  logic [DLY_W-1:0]  holdCnt;
  entryKind_e        curKind;
  logic [DATA_W-1:0] curData;
  logic              launch;
  logic              active;

  assign launch = (state == SEQ_IDLE) && !fifoEmpty && nandRdy;
  assign active = (state == SEQ_ACTIVE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      holdCnt <= '0;
      curKind <= KIND_CMD;
      curData <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (launch) begin
            state   <= SEQ_ACTIVE;
            curKind <= headKind;
            curData <= headData;
            holdCnt <= (headKind == KIND_READ) ? rdDly : wrDly;
          end
        end
        SEQ_ACTIVE: begin
          if (holdCnt == '0) state <= SEQ_RECOVER;
          else               holdCnt <= holdCnt - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.pop      = launch;
    strobes.done     = active && (holdCnt == '0);
    strobes.capture  = active && (holdCnt == '0) && (curKind == KIND_READ);
    strobes.doneKind = curKind;
  end

  assign nandCle  = active && (curKind == KIND_CMD);
  assign nandAle  = active && (curKind == KIND_ADDR);
  assign nandWeN  = !(active && (curKind != KIND_READ));
  assign nandReN  = !(active && (curKind == KIND_READ));
  assign nandIoOe = active && (curKind != KIND_READ);
  assign nandIoOut = (curKind == KIND_DATA && wide) ? curData
                                                    : {{(DATA_W-8){1'b0}}, curData[7:0]};

  // R4: never both strobes low at once
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));
  // R2: latch enables exclusive
  a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));
  // R5: a strobe only falls after the flash was ready
  a_r5_start_on_ready: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nandWeN) || $fell(nandReN)) |-> $past(nandRdy));
  // R3: no pop from an empty buffer
  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> !fifoEmpty);

endmodule

// File: rtl/nand_host_dp.sv
module nand_host_dp
  import nand_host_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DLY_W      = 4,
  parameter int DEPTH      = 4,
  parameter int PAGE_SMALL = 256,
  parameter int PAGE_LARGE = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] nandIoIn,
  input  logic              nandRdy,
  input  seqStrobe_t        strobes,
  output logic              fifoEmpty,
  output entryKind_e        headKind,
  output logic [DATA_W-1:0] headData,
  output logic [DLY_W-1:0]  rdDly,
  output logic [DLY_W-1:0]  wrDly,
  output logic              wide,
  output logic              irqOut
);

  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int CTRL_W = 2 + 2 * DLY_W;
  localparam int UNIT_W = $clog2(PAGE_LARGE) + 1;
  localparam int RDLY_LO = 2;
  localparam int WDLY_LO = 2 + DLY_W;

  // register state
  logic [CTRL_W-1:0]   ctrlReg;
  logic [IRQ_BITS-1:0] irqFlags;
  logic [IRQ_BITS-1:0] irqMask;
  logic [DATA_W-1:0]   rdDataReg;
  logic                pgRdPend;
  logic                pgWrPend;
  logic [UNIT_W-1:0]   unitCnt;
  logic                rdyQ;
  logic                fullQ;

  // buffer state
  entryKind_e          kindMem [DEPTH];
  logic [DATA_W-1:0]   dataMem [DEPTH];
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;
  logic [CNT_W-1:0]    count;

  // decode
  logic wrCtrl, wrIrq, wrMask, wrPage, wrCntRst;
  logic pushReq, pushOk, fifoFull;
  entryKind_e pushKind;

  assign wrCtrl   = regWrEn && (regAddr == OFS_CTRL);
  assign wrIrq    = regWrEn && (regAddr == OFS_IRQ);
  assign wrMask   = regWrEn && (regAddr == OFS_MASK);
  assign wrPage   = regWrEn && (regAddr == OFS_PAGE);
  assign wrCntRst = regWrEn && (regAddr == OFS_CNTRST) && regWrData[0];

  always_comb begin
    pushReq  = 1'b0;
    pushKind = KIND_CMD;
    if (regWrEn) begin
      case (regAddr)
        OFS_CMD:   begin pushReq = 1'b1; pushKind = KIND_CMD;  end
        OFS_ADDR:  begin pushReq = 1'b1; pushKind = KIND_ADDR; end
        OFS_DATA:  begin pushReq = 1'b1; pushKind = KIND_DATA; end
        OFS_RDREQ: begin pushReq = 1'b1; pushKind = KIND_READ; end
        default:   ;
      endcase
    end
  end

  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign pushOk    = pushReq && !fifoFull;
  assign headKind  = kindMem[rdPtr];
  assign headData  = dataMem[rdPtr];

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // write buffer storage, one slot per generate branch
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        kindMem[g] <= KIND_CMD;
        dataMem[g] <= '0;
      end else if (pushOk && wrPtr == PTR_W'(g)) begin
        kindMem[g] <= pushKind;
        dataMem[g] <= regWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk)      wrPtr <= ptrNext(wrPtr);
      if (strobes.pop) rdPtr <= ptrNext(rdPtr);
      case ({pushOk, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  // control fields
  assign wide  = ctrlReg[1];
  assign rdDly = ctrlReg[RDLY_LO +: DLY_W];
  assign wrDly = ctrlReg[WDLY_LO +: DLY_W];

  // page accounting
  logic [UNIT_W-1:0] unitTarget;
  logic lastUnit, wrUnit, rdUnit, wrPageEnd, rdPageEnd;

  assign unitTarget = (ctrlReg[0] ? UNIT_W'(PAGE_LARGE) : UNIT_W'(PAGE_SMALL)) >> ctrlReg[1];
  assign lastUnit   = (unitCnt == unitTarget - 1'b1);
  assign wrUnit     = strobes.done && (strobes.doneKind == KIND_DATA) && pgWrPend;
  assign rdUnit     = strobes.done && (strobes.doneKind == KIND_READ) && pgRdPend;
  assign wrPageEnd  = wrUnit && lastUnit;
  assign rdPageEnd  = rdUnit && lastUnit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitCnt  <= '0;
      pgRdPend <= 1'b0;
      pgWrPend <= 1'b0;
    end else begin
      if (wrCntRst)                 unitCnt <= '0;
      else if (wrUnit || rdUnit)    unitCnt <= lastUnit ? '0 : unitCnt + 1'b1;

      if (wrPage && regWrData[1])   pgWrPend <= 1'b1;
      else if (wrPageEnd)           pgWrPend <= 1'b0;

      if (wrPage && regWrData[0])   pgRdPend <= 1'b1;
      else if (rdPageEnd)           pgRdPend <= 1'b0;
    end
  end

  // interrupt flags: hardware set beats software clear
  logic [IRQ_BITS-1:0] irqSet;
  logic [IRQ_BITS-1:0] irqClr;

  always_comb begin
    irqSet               = '0;
    irqSet[IRQ_NOTBUSY]  = nandRdy && !rdyQ;
    irqSet[IRQ_OVERFLOW] = pushReq && fifoFull;
    irqSet[IRQ_LEAVEFUL] = fullQ && !fifoFull;
    irqSet[IRQ_RDREADY]  = strobes.capture;
    irqSet[IRQ_PGWDONE]  = wrPageEnd;
    irqClr = wrIrq ? regWrData[IRQ_BITS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      irqFlags  <= '0;
      irqMask   <= '0;
      rdDataReg <= '0;
      rdyQ      <= 1'b1;
      fullQ     <= 1'b0;
    end else begin
      rdyQ     <= nandRdy;
      fullQ    <= fifoFull;
      irqFlags <= (irqFlags & ~irqClr) | irqSet;
      if (wrCtrl) ctrlReg <= regWrData[CTRL_W-1:0];
      if (wrMask) irqMask <= regWrData[IRQ_BITS-1:0];
      if (strobes.capture)
        rdDataReg <= wide ? nandIoIn : {{(DATA_W-8){1'b0}}, nandIoIn[7:0]};
    end
  end

  assign irqOut = |(irqFlags & irqMask);

  // register read mux
  always_comb begin
    case (regAddr)
      OFS_CTRL:   regRdData = DATA_W'(ctrlReg);
      OFS_STATUS: regRdData = DATA_W'({fifoEmpty, pgRdPend, pgWrPend, fifoFull, rdyQ});
      OFS_IRQ:    regRdData = DATA_W'(irqFlags);
      OFS_MASK:   regRdData = DATA_W'(irqMask);
      OFS_RDDATA: regRdData = rdDataReg;
      default:    regRdData = '0;
    endcase
  end

  // R3: occupancy bounded
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R3: a rejected write raises overflow and leaves occupancy alone
  a_r3_drop_flags: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && fifoFull && !strobes.pop) |=> (irqFlags[IRQ_OVERFLOW] && count == $past(count)));
  // R6: completed read raises read-ready
  a_r6_ready_after_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> irqFlags[IRQ_RDREADY]);
  // R10: page write done flag only at end of a pending page
  a_r10_done_ends_page: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlags[IRQ_PGWDONE]) |-> ($past(pgWrPend) && !pgWrPend));

endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
  import nand_host_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DLY_W      = 4,
  parameter int DEPTH      = 4,
  parameter int PAGE_SMALL = 256,
  parameter int PAGE_LARGE = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandIoOut,
  output logic              nandIoOe,
  input  logic [DATA_W-1:0] nandIoIn,
  input  logic              nandRdy,
  output logic              irqOut
);

  seqStrobe_t        strobes;
  logic              fifoEmpty;
  entryKind_e        headKind;
  logic [DATA_W-1:0] headData;
  logic [DLY_W-1:0]  rdDly;
  logic [DLY_W-1:0]  wrDly;
  logic              wide;

  nand_host_dp #(
    .DATA_W(DATA_W), .DLY_W(DLY_W), .DEPTH(DEPTH),
    .PAGE_SMALL(PAGE_SMALL), .PAGE_LARGE(PAGE_LARGE)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .nandIoIn(nandIoIn), .nandRdy(nandRdy), .strobes(strobes),
    .fifoEmpty(fifoEmpty), .headKind(headKind), .headData(headData),
    .rdDly(rdDly), .wrDly(wrDly), .wide(wide), .irqOut(irqOut)
  );

  nand_host_seq #(.DATA_W(DATA_W), .DLY_W(DLY_W)) seq_i (
    .clk(clk), .rstN(rstN),
    .fifoEmpty(fifoEmpty), .headKind(headKind), .headData(headData),
    .nandRdy(nandRdy), .rdDly(rdDly), .wrDly(wrDly), .wide(wide),
    .strobes(strobes),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandIoOut(nandIoOut), .nandIoOe(nandIoOe)
  );

endmodule

// File: tb/nand_host_regs_tb_top.sv
`timescale 1ns/1ps
module nand_host_regs_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        nandCle, nandAle, nandWeN, nandReN, nandIoOe, irqOut;
  logic [15:0] nandIoOut;
  logic [15:0] nandIoIn = 16'hBEEF;
  logic        nandRdy = 1'b1;

  always #2 clk = ~clk;

  nand_host_regs dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandIoOut(nandIoOut), .nandIoOe(nandIoOe), .nandIoIn(nandIoIn),
    .nandRdy(nandRdy), .irqOut(irqOut)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bus monitor: one log record per strobe pulse
  int logKind [2048];
  int logData [2048];
  int logLen  [2048];
  int logOe   [2048];
  int logCnt = 0;
  int curLen = 0;
  int curKind = 0;
  int curData = 0;
  int curOe = 0;

  always @(negedge clk) begin
    if (!nandWeN || !nandReN) begin
      curLen  = curLen + 1;
      curKind = !nandReN ? 3 : (nandCle ? 0 : (nandAle ? 1 : 2));
      curData = int'(nandIoOut);
      curOe   = int'(nandIoOe);
    end else if (curLen > 0) begin
      if (logCnt < 2048) begin
        logKind[logCnt] = curKind;
        logData[logCnt] = curData;
        logLen[logCnt]  = curLen;
        logOe[logCnt]   = curOe;
        logCnt = logCnt + 1;
      end
      curLen = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1;
    v = int'(regRdData);
  endtask

  task automatic pushWait(input logic [3:0] a, input logic [15:0] d);
    int s;
    regRead(4'd1, s);
    while (s[1]) regRead(4'd1, s);
    regWrite(a, d);
  endtask

  task automatic drain();
    int s;
    regRead(4'd1, s);
    while (!s[4]) regRead(4'd1, s);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, base;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    regRead(4'd1, v); chk("R1 status", v, 'h11);
    regRead(4'd2, v); chk("R1 irq flags", v, 0);
    chk("R1 irqOut", int'(irqOut), 0);
    chk("R1 strobes", int'({nandWeN, nandReN}), 3);

    // R2 ordering and latch kinds
    base = logCnt;
    regWrite(4'd4, 16'h0090);
    regWrite(4'd5, 16'h0000);
    regWrite(4'd6, 16'h005A);
    drain();
    chk("R2 count", logCnt - base, 3);
    chk("R2 kind cmd",  logKind[base],   0);
    chk("R2 data cmd",  logData[base],   'h90);
    chk("R2 kind addr", logKind[base+1], 1);
    chk("R2 data addr", logData[base+1], 0);
    chk("R2 kind data", logKind[base+2], 2);
    chk("R2 data data", logData[base+2], 'h5A);
    chk("R2 oe", logOe[base+2], 1);

    // R4 sweep of both delays
    for (int d = 0; d < 16; d++) begin
      regWrite(4'd0, 16'(d << 6));
      base = logCnt;
      regWrite(4'd4, 16'(d));
      drain();
      chk("R4 write strobe len", logLen[base], d + 1);
    end
    for (int d = 0; d < 16; d++) begin
      regWrite(4'd0, 16'(d << 2));
      base = logCnt;
      regWrite(4'd7, 16'h0);
      drain();
      chk("R4 read strobe len", logLen[base], d + 1);
      chk("R4 read kind", logKind[base], 3);
    end
    regWrite(4'd0, 16'h0);
    regWrite(4'd2, 16'h1F);

    // R3 / R5 / R7: fill while busy
    nandRdy = 1'b0;
    repeat (3) @(negedge clk);
    base = logCnt;
    for (int i = 0; i < 5; i++) regWrite(4'd4, 16'(16 + i));
    repeat (5) @(negedge clk);
    regRead(4'd1, v); chk("R3 full status, R5 busy", v, 'h02);
    regRead(4'd2, v); chk("R3 overflow flag", v, 'h02);
    chk("R5 nothing started while busy", logCnt - base, 0);
    nandRdy = 1'b1;
    drain();
    regRead(4'd2, v); chk("R7 notbusy and leave-full flags", v, 'h07);
    chk("R3 only four executed", logCnt - base, 4);
    for (int i = 0; i < 4; i++) chk("R3 order kept", logData[base+i], 16 + i);

    // R8 write-one-to-clear
    regWrite(4'd2, 16'h05);
    regRead(4'd2, v); chk("R8 selective clear", v, 'h02);
    regWrite(4'd2, 16'h00);
    regRead(4'd2, v); chk("R8 zeros no effect", v, 'h02);
    regWrite(4'd2, 16'h02);
    regRead(4'd2, v); chk("R8 cleared", v, 0);

    // R9 mask
    nandRdy = 1'b0; repeat (3) @(negedge clk);
    nandRdy = 1'b1; repeat (3) @(negedge clk);
    regWrite(4'd3, 16'h00); chk("R9 masked off", int'(irqOut), 0);
    regWrite(4'd3, 16'h1E); chk("R9 other bits", int'(irqOut), 0);
    regWrite(4'd3, 16'h01); chk("R9 enabled", int'(irqOut), 1);
    regWrite(4'd2, 16'h01); chk("R9 after clear", int'(irqOut), 0);
    regWrite(4'd3, 16'h00);

    // R8 collision: set and clear in the same clock
    nandRdy = 1'b0; repeat (3) @(negedge clk);
    @(negedge clk);
    nandRdy = 1'b1; regAddr = 4'd2; regWrData = 16'h01; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    regRead(4'd2, v); chk("R8 set wins over clear", v & 1, 1);
    regWrite(4'd2, 16'h1F);

    // R6 / R12 reads and widths
    nandIoIn = 16'hBEEF;
    base = logCnt;
    regWrite(4'd7, 16'h1234);
    drain();
    regRead(4'd8, v); chk("R12 8-bit read zero-extended", v, 'hEF);
    regRead(4'd2, v); chk("R6 read ready", v, 'h08);
    chk("R6 bus not driven on read", logOe[base], 0);
    chk("R6 read kind", logKind[base], 3);
    regWrite(4'd6, 16'hA5C3);
    drain();
    chk("R12 8-bit write low byte", logData[base+1], 'hC3);
    regWrite(4'd0, 16'h2);
    nandIoIn = 16'h7E81;
    regWrite(4'd7, 16'h0);
    regWrite(4'd6, 16'hA5C3);
    drain();
    regRead(4'd8, v); chk("R12 16-bit read", v, 'h7E81);
    chk("R12 16-bit write", logData[base+3], 'hA5C3);
    regWrite(4'd2, 16'h1F);

    // R10 page write: 256 bytes, 16-bit => 128 words
    regWrite(4'd0, 16'h2);
    regWrite(4'd10, 16'h1);
    regWrite(4'd9, 16'h2);
    regRead(4'd1, v); chk("R10 write pending", (v >> 2) & 1, 1);
    for (int i = 0; i < 127; i++) pushWait(4'd6, 16'(i));
    drain();
    regRead(4'd1, v); chk("R10 still pending", (v >> 2) & 1, 1);
    regRead(4'd2, v); chk("R10 no done yet", (v >> 4) & 1, 0);
    regWrite(4'd6, 16'h0);
    drain();
    regRead(4'd1, v); chk("R10 write finished", (v >> 2) & 1, 0);
    regRead(4'd2, v); chk("R10 done flag", (v >> 4) & 1, 1);

    // R10 page read: 512 bytes, 16-bit => 256 words
    regWrite(4'd0, 16'h3);
    regWrite(4'd10, 16'h1);
    regWrite(4'd9, 16'h1);
    regRead(4'd1, v); chk("R10 read pending", (v >> 3) & 1, 1);
    for (int i = 0; i < 255; i++) pushWait(4'd7, 16'h0);
    drain();
    regRead(4'd1, v); chk("R10 read still pending", (v >> 3) & 1, 1);
    regWrite(4'd7, 16'h0);
    drain();
    regRead(4'd1, v); chk("R10 read finished", (v >> 3) & 1, 0);

    // R11 counter reset mid page
    regWrite(4'd0, 16'h2);
    regWrite(4'd10, 16'h1);
    regWrite(4'd2, 16'h1F);
    regWrite(4'd9, 16'h2);
    for (int i = 0; i < 10; i++) pushWait(4'd6, 16'(i));
    drain();
    regWrite(4'd10, 16'h1);
    for (int i = 0; i < 127; i++) pushWait(4'd6, 16'(i));
    drain();
    regRead(4'd1, v); chk("R11 count restarted", (v >> 2) & 1, 1);
    regWrite(4'd6, 16'h0);
    drain();
    regRead(4'd1, v); chk("R11 page ends after full count", (v >> 2) & 1, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule